// File: doc/BRIEF.md
# Activity and Temperature Driven Operating-Point Governor

This block picks one of three chip operating points (low, middle, high) from two sources: the compute activity count reported once per measurement window, and the temperature readings of every sensor in every cluster. Code 0 is the low point (100 MHz at 0.6 V), code 1 the middle point (500 MHz at 0.8 V) and code 2 the high point (1 GHz at 1.0 V). The same 2-bit code goes to the voltage regulator and to the clock generator. Each of these two interfaces uses a request that stays high until a one-cycle acknowledge arrives.

Activity samples arrive on a valid/ready stream. A sample is taken on a clock edge where `act_valid` and `act_ready` are both high. The block lowers `act_ready` while a voltage or frequency change is waiting for its acknowledge. The source must then hold the sample until `act_ready` returns, so no sample is lost and none is taken in the middle of a transition. The hottest sensor is compared against a programmable limit. While it is too hot, the governor asks for one step below the level that activity alone would select, and it raises `throttle`.

When the block moves up, it raises the voltage first and the frequency second. When it moves down, it lowers the frequency first and the voltage second. The clock is therefore never faster than the supply voltage permits.

Top module: `dvfs_governor`

## Requirements
- R1: After reset, `volt_code` and `freq_code` are 0, `volt_req`, `freq_req` and `throttle` are low, and `act_ready` is high.
- R2: The activity level rises by one step only when two consecutive accepted samples are strictly above the upper threshold of the next level (`up_thr_mid` from level 0, `up_thr_peak` from level 1). A single such sample followed by one that does not exceed the threshold leaves the level unchanged.
- R3: One accepted sample strictly below the lower threshold of the current level (`dn_thr_mid` at level 1, `dn_thr_peak` at level 2) drops the activity level by one step.
- R4: Raising the operating point first drives `volt_req` with the new `volt_code`. `freq_req` with the new `freq_code` follows only after `volt_ack`. `freq_code` never exceeds `volt_code`.
- R5: Lowering the operating point first drives `freq_req` with the new `freq_code`. `volt_req` with the new `volt_code` follows only after `freq_ack`.
- R6: A request stays high with a stable code until its acknowledge arrives. `volt_req` and `freq_req` are never high together. `act_ready` is low while either request is high.
- R7: When the maximum over all sensors is strictly above `temp_limit`, `throttle` goes high one cycle later. The target becomes one level below the activity level, and never lower than level 0.
- R8: Once set, `throttle` stays high until the maximum plus `temp_hyst` is strictly below `temp_limit`. The target then returns to the activity level.
- R9: Once all acknowledges are received, `volt_code` and `freq_code` both equal the target level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activity sample valid |
| act_ready | output | 1 | Governor can accept a sample |
| act_count | input | ACT_W | Activity count for one window |
| up_thr_mid | input | ACT_W | Count to exceed to enter level 1 |
| dn_thr_mid | input | ACT_W | Count to fall below to leave level 1 |
| up_thr_peak | input | ACT_W | Count to exceed to enter level 2 |
| dn_thr_peak | input | ACT_W | Count to fall below to leave level 2 |
| temp_bus | input | NUM_CLUSTERS*SENS_PER_CLUSTER*TEMP_W | All sensor readings, sensor 0 in the low bits |
| temp_limit | input | TEMP_W | Throttle limit |
| temp_hyst | input | TEMP_W | Release margin below the limit |
| volt_req | output | 1 | Voltage change request |
| volt_code | output | 2 | Requested voltage level code |
| volt_ack | input | 1 | Regulator acknowledge, one cycle |
| freq_req | output | 1 | Frequency change request |
| freq_code | output | 2 | Requested frequency level code |
| freq_ack | input | 1 | Clock generator acknowledge, one cycle |
| throttle | output | 1 | Thermal throttle active |

## Verification
An accepted sample updates the activity level at its own edge, and the first request appears after the following edge. A temperature change sets or clears `throttle` one edge after it is applied, and any request it causes follows one edge later. The end of a transition depends on the acknowledge delay, which the bench's responders randomise between 0 and 3 cycles. For that reason the bench checks `throttle` exactly one edge after each temperature change, but checks the settled codes only after a fixed 24-cycle wait. That wait covers two requests at the longest acknowledge delay. The order of the first request, and the back-pressure while busy, are watched on every falling edge.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef logic [1:0] opl_t;
  localparam opl_t OPL_LOW  = 2'd0;
  localparam opl_t OPL_MID  = 2'd1;
  localparam opl_t OPL_HIGH = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_V_UP,
    SQ_F_UP,
    SQ_F_DN,
    SQ_V_DN
  } seq_state_t;
endpackage

// File: rtl/dvfs_temp_max.sv
module dvfs_temp_max #(
  parameter int TEMP_W   = 8,
  parameter int NUM_SENS = 16
) (
  input  logic [NUM_SENS*TEMP_W-1:0] temp_bus,
  output logic [TEMP_W-1:0]          temp_max
);
  logic [TEMP_W-1:0] run_max [NUM_SENS];

  assign run_max[0] = temp_bus[TEMP_W-1:0];

  for (genvar g = 1; g < NUM_SENS; g++) begin : g_chain
    logic [TEMP_W-1:0] rd;
    assign rd         = temp_bus[g*TEMP_W +: TEMP_W];
    assign run_max[g] = (rd > run_max[g-1]) ? rd : run_max[g-1];
  end

  assign temp_max = run_max[NUM_SENS-1];
endmodule

// File: rtl/dvfs_thermal.sv
module dvfs_thermal #(
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_max,
  input  logic [TEMP_W-1:0] temp_limit,
  input  logic [TEMP_W-1:0] temp_hyst,
  output logic              hot
);
  localparam int SUM_W = TEMP_W + 1;

  logic [SUM_W-1:0] relax_sum;
  assign relax_sum = {1'b0, temp_max} + {1'b0, temp_hyst};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot <= 1'b0;
    end else if (!hot && (temp_max > temp_limit)) begin
      hot <= 1'b1;
    end else if (hot && (relax_sum < {1'b0, temp_limit})) begin
      hot <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_act_policy.sv
module dvfs_act_policy
  import dvfs_pkg::*;
#(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [ACT_W-1:0] count,
  input  logic [ACT_W-1:0] up_thr_mid,
  input  logic [ACT_W-1:0] dn_thr_mid,
  input  logic [ACT_W-1:0] up_thr_peak,
  input  logic [ACT_W-1:0] dn_thr_peak,
  output opl_t             act_lvl
);
  logic             armed;
  logic [ACT_W-1:0] up_sel, dn_sel;
  logic             can_up, can_dn, over, under;

  assign up_sel = (act_lvl == OPL_LOW)  ? up_thr_mid  : up_thr_peak;
  assign dn_sel = (act_lvl == OPL_HIGH) ? dn_thr_peak : dn_thr_mid;
  assign can_up = (act_lvl != OPL_HIGH);
  assign can_dn = (act_lvl != OPL_LOW);
  assign over   = can_up && (count > up_sel);
  assign under  = can_dn && (count < dn_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_lvl <= OPL_LOW;
      armed   <= 1'b0;
    end else if (take) begin
      if (over) begin
        if (armed) begin
          act_lvl <= opl_t'(act_lvl + 2'd1);
          armed   <= 1'b0;
        end else begin
          armed   <= 1'b1;
        end
      end else if (under) begin
        act_lvl <= opl_t'(act_lvl - 2'd1);
        armed   <= 1'b0;
      end else begin
        armed   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
  import dvfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  opl_t target,
  output logic busy,
  output logic volt_req,
  output opl_t volt_code,
  input  logic volt_ack,
  output logic freq_req,
  output opl_t freq_code,
  input  logic freq_ack
);
  seq_state_t st;
  opl_t       tgt;

  assign busy = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      tgt       <= OPL_LOW;
      volt_req  <= 1'b0;
      freq_req  <= 1'b0;
      volt_code <= OPL_LOW;
      freq_code <= OPL_LOW;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (target > freq_code) begin
            tgt       <= target;
            volt_code <= target;
            volt_req  <= 1'b1;
            st        <= SQ_V_UP;
          end else if (target < freq_code) begin
            tgt       <= target;
            freq_code <= target;
            freq_req  <= 1'b1;
            st        <= SQ_F_DN;
          end
        end
        SQ_V_UP: if (volt_ack) begin
          volt_req  <= 1'b0;
          freq_code <= tgt;
          freq_req  <= 1'b1;
          st        <= SQ_F_UP;
        end
        SQ_F_UP: if (freq_ack) begin
          freq_req <= 1'b0;
          st       <= SQ_IDLE;
        end
        SQ_F_DN: if (freq_ack) begin
          freq_req  <= 1'b0;
          volt_code <= tgt;
          volt_req  <= 1'b1;
          st        <= SQ_V_DN;
        end
        SQ_V_DN: if (volt_ack) begin
          volt_req <= 1'b0;
          st       <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_governor.sv
module dvfs_governor
  import dvfs_pkg::*;
#(
  parameter int ACT_W            = 16,
  parameter int TEMP_W           = 8,
  parameter int NUM_CLUSTERS     = 4,
  parameter int SENS_PER_CLUSTER = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           act_valid,
  output logic                                           act_ready,
  input  logic [ACT_W-1:0]                               act_count,
  input  logic [ACT_W-1:0]                               up_thr_mid,
  input  logic [ACT_W-1:0]                               dn_thr_mid,
  input  logic [ACT_W-1:0]                               up_thr_peak,
  input  logic [ACT_W-1:0]                               dn_thr_peak,
  input  logic [NUM_CLUSTERS*SENS_PER_CLUSTER*TEMP_W-1:0] temp_bus,
  input  logic [TEMP_W-1:0]                              temp_limit,
  input  logic [TEMP_W-1:0]                              temp_hyst,
  output logic                                           volt_req,
  output logic [1:0]                                     volt_code,
  input  logic                                           volt_ack,
  output logic                                           freq_req,
  output logic [1:0]                                     freq_code,
  input  logic                                           freq_ack,
  output logic                                           throttle
);
  localparam int NUM_SENS = NUM_CLUSTERS * SENS_PER_CLUSTER;

  logic [TEMP_W-1:0] temp_max;
  logic              hot, busy;
  opl_t              act_lvl, target;

  assign act_ready = !busy;
  assign throttle  = hot;
  assign target    = !hot ? act_lvl :
                     (act_lvl == OPL_LOW) ? OPL_LOW : opl_t'(act_lvl - 2'd1);

  dvfs_temp_max #(.TEMP_W(TEMP_W), .NUM_SENS(NUM_SENS)) max_i (
    .temp_bus (temp_bus),
    .temp_max (temp_max)
  );

  dvfs_thermal #(.TEMP_W(TEMP_W)) therm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_max   (temp_max),
    .temp_limit (temp_limit),
    .temp_hyst  (temp_hyst),
    .hot        (hot)
  );

  dvfs_act_policy #(.ACT_W(ACT_W)) pol_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (act_valid && act_ready),
    .count       (act_count),
    .up_thr_mid  (up_thr_mid),
    .dn_thr_mid  (dn_thr_mid),
    .up_thr_peak (up_thr_peak),
    .dn_thr_peak (dn_thr_peak),
    .act_lvl     (act_lvl)
  );

  dvfs_sequencer seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .target    (target),
    .busy      (busy),
    .volt_req  (volt_req),
    .volt_code (volt_code),
    .volt_ack  (volt_ack),
    .freq_req  (freq_req),
    .freq_code (freq_code),
    .freq_ack  (freq_ack)
  );
endmodule

// File: rtl/dvfs_governor_chk.sv
module dvfs_governor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act_ready,
  input logic       volt_req,
  input logic [1:0] volt_code,
  input logic       volt_ack,
  input logic       freq_req,
  input logic [1:0] freq_code,
  input logic       freq_ack
);
  // R4
  freq_le_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_code <= volt_code);

  // R4
  up_volt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && (freq_code > $past(freq_code))) |-> $past(volt_ack));

  // R5
  dn_freq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req && (volt_code < $past(volt_code))) |-> $past(freq_ack));

  // R6
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(volt_req && freq_req));

  // R6
  volt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req && !volt_ack) |=> (volt_req && $stable(volt_code)));

  // R6
  freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_req && !freq_ack) |=> (freq_req && $stable(freq_code)));

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_req || freq_req) |-> !act_ready);
endmodule

bind dvfs_governor dvfs_governor_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .act_ready (act_ready),
  .volt_req  (volt_req),
  .volt_code (volt_code),
  .volt_ack  (volt_ack),
  .freq_req  (freq_req),
  .freq_code (freq_code),
  .freq_ack  (freq_ack)
);

// File: tb/dvfs_governor_tb_top.sv
module dvfs_governor_tb_top;
  localparam int ACT_W = 16;
  localparam int TEMP_W = 8;
  localparam int NS = 16;
  localparam int UPM = 100, DNM = 60, UPP = 200, DNP = 150;
  localparam int LIM = 90, HYS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_valid = 1'b0;
  logic act_ready;
  logic [ACT_W-1:0] act_count = '0;
  logic [NS*TEMP_W-1:0] temp_bus = '0;
  logic volt_req, freq_req, throttle;
  logic [1:0] volt_code, freq_code;
  logic volt_ack = 1'b0;
  logic freq_ack = 1'b0;

  always #2 clk = ~clk;

  dvfs_governor dut_i (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(act_ready),
    .act_count(act_count),
    .up_thr_mid(ACT_W'(UPM)), .dn_thr_mid(ACT_W'(DNM)),
    .up_thr_peak(ACT_W'(UPP)), .dn_thr_peak(ACT_W'(DNP)),
    .temp_bus(temp_bus), .temp_limit(TEMP_W'(LIM)), .temp_hyst(TEMP_W'(HYS)),
    .volt_req(volt_req), .volt_code(volt_code), .volt_ack(volt_ack),
    .freq_req(freq_req), .freq_code(freq_code), .freq_ack(freq_ack),
    .throttle(throttle)
  );

  int n_chk = 0, n_err = 0;
  int m_lvl = 0;
  bit m_armed = 0, m_hot = 0;
  int temps [NS];
  int ack_fix = -1;
  int mon_first = 0;
  int inv_err = 0;
  bit pv = 0, pf = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level();
    if (m_hot) return (m_lvl == 0) ? 0 : m_lvl - 1;
    return m_lvl;
  endfunction

  function automatic int temp_max();
    int mx = temps[0];
    for (int i = 1; i < NS; i++) if (temps[i] > mx) mx = temps[i];
    return mx;
  endfunction

  // ack responders
  initial forever begin
    @(negedge clk);
    if (volt_req) begin
      repeat ((ack_fix >= 0) ? ack_fix : int'($urandom_range(0, 3))) @(negedge clk);
      volt_ack = 1'b1;
      @(negedge clk);
      volt_ack = 1'b0;
    end
  end
  initial forever begin
    @(negedge clk);
    if (freq_req) begin
      repeat ((ack_fix >= 0) ? ack_fix : int'($urandom_range(0, 3))) @(negedge clk);
      freq_ack = 1'b1;
      @(negedge clk);
      freq_ack = 1'b0;
    end
  end

  // order and back-pressure monitor (R4, R5, R6)
  always @(negedge clk) begin
    if (rst_n) begin
      if ((volt_req || freq_req) && !pv && !pf && mon_first == 0)
        mon_first = volt_req ? 1 : 2;
      if (freq_code > volt_code) inv_err++;
      if (volt_req && freq_req) inv_err++;
      if ((volt_req || freq_req) && act_ready) inv_err++;
      pv = volt_req;
      pf = freq_req;
    end
  end

  task automatic apply_temps();
    int mx;
    @(negedge clk);
    for (int i = 0; i < NS; i++) temp_bus[i*TEMP_W +: TEMP_W] = TEMP_W'(temps[i]);
    mx = temp_max();
    if (!m_hot && mx > LIM) m_hot = 1;
    else if (m_hot && mx + HYS < LIM) m_hot = 0;
  endtask

  task automatic send_sample(int cnt);
    @(negedge clk);
    while (!act_ready) @(negedge clk);
    act_valid = 1'b1;
    act_count = ACT_W'(cnt);
    @(negedge clk);
    act_valid = 1'b0;
    if (m_lvl < 2 && cnt > ((m_lvl == 0) ? UPM : UPP)) begin
      if (m_armed) begin m_lvl++; m_armed = 0; end
      else m_armed = 1;
    end else if (m_lvl > 0 && cnt < ((m_lvl == 2) ? DNP : DNM)) begin
      m_lvl--; m_armed = 0;
    end else m_armed = 0;
  endtask

  task automatic settle(int prev, string tag);
    int e = exp_level();
    repeat (24) @(negedge clk);
    chk(volt_code == 2'(e), {tag, " R9 volt_code"}, volt_code, e);
    chk(freq_code == 2'(e), {tag, " R9 freq_code"}, freq_code, e);
    if (e > prev) chk(mon_first == 1, {tag, " R4 volt first"}, mon_first, 1);
    else if (e < prev) chk(mon_first == 2, {tag, " R5 freq first"}, mon_first, 2);
    else chk(mon_first == 0, {tag, " no request"}, mon_first, 0);
    mon_first = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int prev;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NS; i++) temps[i] = 50;
    for (int i = 0; i < NS; i++) temp_bus[i*TEMP_W +: TEMP_W] = TEMP_W'(50);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(volt_code == 0 && freq_code == 0, "R1 codes", {volt_code, freq_code}, 0);
    chk(!volt_req && !freq_req, "R1 requests", {volt_req, freq_req}, 0);
    chk(!throttle, "R1 throttle", throttle, 0);
    chk(act_ready, "R1 ready", act_ready, 1);

    // R2: single exceed then quiet -> no change
    prev = exp_level(); send_sample(150); send_sample(80); settle(prev, "R2 single");
    chk(m_lvl == 0, "R2 model", m_lvl, 0);
    // R2: two in a row -> up
    prev = exp_level(); send_sample(150); send_sample(150); settle(prev, "R2 double");
    prev = exp_level(); send_sample(250); send_sample(250); settle(prev, "R2 to peak");
    // R3: one below -> down
    prev = exp_level(); send_sample(120); settle(prev, "R3 down");

    // R6: busy back-pressure and held request
    ack_fix = 3;
    prev = exp_level(); send_sample(250); send_sample(250);
    @(negedge clk);
    chk(volt_req && !act_ready, "R6 busy stall", {volt_req, act_ready}, 2);
    @(negedge clk);
    chk(volt_req && volt_code == 2'd2, "R6 held req", {volt_req, volt_code}, 6);
    settle(prev, "R6 finish");
    ack_fix = -1;

    // R7: one hot sensor (cluster 3, sensor 2)
    prev = exp_level(); temps[14] = 95; apply_temps();
    @(negedge clk);
    chk(throttle, "R7 throttle set", throttle, 1);
    settle(prev, "R7 lowered");
    // R8: inside hysteresis band stays, below releases
    prev = exp_level(); temps[14] = 85; apply_temps(); settle(prev, "R8 band");
    chk(throttle, "R8 band throttle", throttle, 1);
    prev = exp_level(); temps[14] = 79; apply_temps();
    @(negedge clk);
    chk(!throttle, "R8 release", throttle, 0);
    settle(prev, "R8 restored");
    // R7 at idle: no lower than level 0
    prev = exp_level(); send_sample(10); settle(prev, "R3 d1");
    prev = exp_level(); send_sample(10); settle(prev, "R3 d2");
    prev = exp_level(); temps[3] = 120; apply_temps(); settle(prev, "R7 idle floor");
    chk(throttle && volt_code == 0, "R7 idle floor", volt_code, 0);
    prev = exp_level(); temps[3] = 40; apply_temps(); settle(prev, "R8 idle release");

    // random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(0, 4) == 0) begin
        temps[$urandom_range(0, NS-1)] = $urandom_range(40, 100);
        prev = exp_level(); apply_temps(); settle(prev, "rand temp R7");
        chk(throttle == m_hot, "rand R8 throttle", throttle, m_hot);
      end
      prev = exp_level(); send_sample($urandom_range(0, 299)); settle(prev, "rand R2 R3");
    end

    chk(inv_err == 0, "R4 R5 R6 monitor", inv_err, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule